// File: doc/BRIEF.md
# Shadow Configuration Commit and Interrupt Collector

This block sits between a register port and a display datapath. Software writes configuration words into a shadow bank while the datapath keeps running on an active bank. The active bank changes only when software asks for a commit. A commit can take effect on the next clock, which is the form used when the display is switched on or off. It can also wait until the vertical counter first reaches the last active line, which is the form used for normal frame updates, so that a frame is never built from a mix of old and new settings.

Every commit raises a commit-done event. That event is collected with three datapath events (line reached, FIFO underrun and transfer error) into a sticky status register. Each status bit has its own enable. Status bits are cleared by writing ones to a separate clear register, and a single interrupt line is raised while any enabled status bit is set.

Top module: `srr_unit`

## Requirements
- R1: After reset the active bank, the shadow bank, the pending requests, the enable register and the status register are all zero, and `irq` is low.
- R2: A write to configuration word k (address 4+k) changes only the shadow copy, and reading it back returns that value. `cfg_active` keeps its value until a commit.
- R3: Writing a one to bit 0 of the reload register (address 0) makes bit 0 of that register read as 1 for one cycle. On the next clock the whole shadow bank is copied to `cfg_active` and the bit reads 0 again.
- R4: Writing a one to bit 1 of the reload register while `disp_en` is high keeps bit 1 pending. The copy happens at the first clock where `vcount` equals `vend` after a cycle in which it did not. If `vcount` merely stays at `vend`, no further copy takes place.
- R5: A pending bit-1 request while `disp_en` is low is carried out on the next clock, as for bit 0.
- R6: When both request bits are pending, a single copy is made and both bits clear together.
- R7: Status bit 3 (commit done) is set by the same clock edge that updates `cfg_active`.
- R8: Status bits are set by their sources whether or not they are enabled. The layout is: bit 0 for `ev_line`, bit 1 for `ev_underrun`, bit 2 for `ev_xfer_err` and bit 3 for commit done. The status register is read at address 2.
- R9: Writing to the clear register (address 3) clears each status bit written as one and leaves the bits written as zero. The clear register reads as zero.
- R10: If a clear and a new source event hit the same status bit in the same cycle, the bit stays set.
- R11: `irq` is high exactly when some status bit and the matching bit of the enable register (address 1, same layout) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| disp_en | input | 1 | Display running; when low, a vertical-blank request commits at once |
| vcount | input | VW | Current vertical line counter |
| vend | input | VW | Line number at which the active area ends |
| ev_line | input | 1 | Line event pulse |
| ev_underrun | input | 1 | FIFO underrun pulse |
| ev_xfer_err | input | 1 | Transfer error pulse |
| cfg_active | output | NUM_CFG*DW | Active configuration bank, word k at bits k*DW upward |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The hardest case to reach is a vertical-blank request that must not fire while the counter sits at the end line. To get there, the bench first parks `vcount` on `vend`, then issues a new request, holds the counter there for several cycles and checks that the request stays pending. It then moves the counter away and back to show that the copy happens on re-entry. The clear-versus-event collision is forced by driving the clear write and the source pulse in the same cycle. The interrupt line is checked against every combination of enable values and three-source status patterns.

// File: rtl/srr_pkg.sv
package srr_pkg;
   localparam int IRQ_N    = 4;
   localparam int IRQ_LINE = 0;
   localparam int IRQ_UNDR = 1;
   localparam int IRQ_XERR = 2;
   localparam int IRQ_RLD  = 3;

   localparam int REQ_NOW  = 0;
   localparam int REQ_VBL  = 1;

   localparam int A_RELOAD = 0;
   localparam int A_ENABLE = 1;
   localparam int A_STATUS = 2;
   localparam int A_CLEAR  = 3;
   localparam int CFG_BASE = 4;

   typedef logic [IRQ_N-1:0] irq_vec_t;
   typedef logic [1:0]       req_vec_t;
endpackage

// File: rtl/srr_shadow_bank.sv
module srr_shadow_bank #(
   parameter int DW      = 32,
   parameter int NUM_CFG = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CFG-1:0]    wr_sel,
   input  logic [DW-1:0]         wdata,
   input  logic                  commit,
   output logic [NUM_CFG*DW-1:0] shadow,
   output logic [NUM_CFG*DW-1:0] active
);
   localparam int BANK_W = NUM_CFG * DW;

   if (DW < 4)      begin : g_bad_dw  $error("DW must be at least 4");      end
   if (NUM_CFG < 1) begin : g_bad_num $error("NUM_CFG must be at least 1"); end

   for (genvar k = 0; k < NUM_CFG; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow[k*DW +: DW] <= '0;
         end else if (wr_sel[k]) begin
            shadow[k*DW +: DW] <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active[k*DW +: DW] <= '0;
         end else if (commit) begin
            active[k*DW +: DW] <= shadow[k*DW +: DW];
         end
      end
   end

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active)); // R2
   AST_COPY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (active == $past(shadow))); // R3

   logic [BANK_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: rtl/srr_reload_ctl.sv
module srr_reload_ctl
   import srr_pkg::*;
#(
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_wr,
   input  req_vec_t      req_bits,
   input  logic          disp_en,
   input  logic [VW-1:0] vcount,
   input  logic [VW-1:0] vend,
   output req_vec_t      pend,
   output logic          commit
);
   if (VW < 2) begin : g_bad_vw $error("VW must be at least 2"); end

   logic at_end, at_end_q, vbl_hit;

   assign at_end  = (vcount == vend);
   assign vbl_hit = at_end && !at_end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) at_end_q <= 1'b0;
      else        at_end_q <= at_end;
   end

   always_comb begin
      commit = pend[REQ_NOW];
      if (pend[REQ_VBL] && (vbl_hit || !disp_en)) commit = 1'b1;
   end

   req_vec_t new_req;
   assign new_req = req_wr ? req_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else if (commit) begin
         pend <= new_req;
      end else begin
         pend <= pend | new_req;
      end
   end

   AST_NOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[REQ_NOW] && !(req_wr && req_bits[REQ_NOW])) |=> !pend[REQ_NOW]); // R3
   AST_VBL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[REQ_VBL] && !pend[REQ_NOW] && disp_en && !vbl_hit) |=> pend[REQ_VBL]); // R4
   AST_OFF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[REQ_VBL] && !disp_en && !(req_wr && req_bits[REQ_VBL])) |=> !pend[REQ_VBL]); // R5
   AST_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == 2'b11 && !req_wr) |=> (pend == 2'b00)); // R6
endmodule

// File: rtl/srr_irq_ctl.sv
module srr_irq_ctl
   import srr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en_wr,
   input  logic     clr_wr,
   input  irq_vec_t wdata,
   input  irq_vec_t src,
   output irq_vec_t en,
   output irq_vec_t status,
   output logic     irq
);
   irq_vec_t clr_mask;
   assign clr_mask = clr_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= '0;
         status <= '0;
      end else begin
         if (en_wr) en <= wdata;
         status <= (status & ~clr_mask) | src;
      end
   end

   assign irq = |(status & en);

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (($past(status) & ~status) == '0)); // R9
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|src) |=> ((status & $past(src)) == $past(src))); // R10
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq); // R11
endmodule

// File: rtl/srr_unit.sv
module srr_unit
   import srr_pkg::*;
#(
   parameter int DW      = 32,
   parameter int ADDR_W  = 4,
   parameter int NUM_CFG = 4,
   parameter int VW      = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DW-1:0]         reg_wdata,
   output logic [DW-1:0]         reg_rdata,
   input  logic                  disp_en,
   input  logic [VW-1:0]         vcount,
   input  logic [VW-1:0]         vend,
   input  logic                  ev_line,
   input  logic                  ev_underrun,
   input  logic                  ev_xfer_err,
   output logic [NUM_CFG*DW-1:0] cfg_active,
   output logic                  irq
);
   localparam int CFG_END = CFG_BASE + NUM_CFG;

   if (CFG_END > (1 << ADDR_W)) begin : g_bad_map
      $error("ADDR_W too small for NUM_CFG configuration words");
   end

   logic [NUM_CFG-1:0]    cfg_sel;
   logic [NUM_CFG*DW-1:0] shadow;
   logic                  wr_reload, wr_enable, wr_clear, commit;
   req_vec_t              pend;
   irq_vec_t              en, status, src;

   assign wr_reload = reg_wr && (reg_addr == ADDR_W'(A_RELOAD));
   assign wr_enable = reg_wr && (reg_addr == ADDR_W'(A_ENABLE));
   assign wr_clear  = reg_wr && (reg_addr == ADDR_W'(A_CLEAR));

   for (genvar k = 0; k < NUM_CFG; k++) begin : g_sel
      assign cfg_sel[k] = reg_wr && (reg_addr == ADDR_W'(CFG_BASE + k));
   end

   assign src[IRQ_LINE] = ev_line;
   assign src[IRQ_UNDR] = ev_underrun;
   assign src[IRQ_XERR] = ev_xfer_err;
   assign src[IRQ_RLD]  = commit;

   srr_shadow_bank #(.DW(DW), .NUM_CFG(NUM_CFG)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (cfg_sel),
      .wdata  (reg_wdata),
      .commit (commit),
      .shadow (shadow),
      .active (cfg_active)
   );

   srr_reload_ctl #(.VW(VW)) u_reload (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_wr   (wr_reload),
      .req_bits (reg_wdata[1:0]),
      .disp_en  (disp_en),
      .vcount   (vcount),
      .vend     (vend),
      .pend     (pend),
      .commit   (commit)
   );

   srr_irq_ctl u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (wr_enable),
      .clr_wr (wr_clear),
      .wdata  (reg_wdata[IRQ_N-1:0]),
      .src    (src),
      .en     (en),
      .status (status),
      .irq    (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_RELOAD)) reg_rdata[1:0]       = pend;
      if (reg_addr == ADDR_W'(A_ENABLE)) reg_rdata[IRQ_N-1:0] = en;
      if (reg_addr == ADDR_W'(A_STATUS)) reg_rdata[IRQ_N-1:0] = status;
      for (int k = 0; k < NUM_CFG; k++) begin
         if (reg_addr == ADDR_W'(CFG_BASE + k)) reg_rdata = shadow[k*DW +: DW];
      end
   end

   AST_FLAG_WITH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> status[IRQ_RLD]); // R7
   AST_SRC_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_underrun && en[IRQ_UNDR] == 1'b0) |=> status[IRQ_UNDR]); // R8
endmodule

// File: tb/srr_unit_bench.sv
module srr_unit_bench;
   localparam int DW = 32, AW = 4, NC = 4, VW = 11;

   logic clk = 0, rst_n = 0, reg_wr = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic disp_en = 0;
   logic [VW-1:0] vcount = '0, vend = 11'd5;
   logic ev_line = 0, ev_underrun = 0, ev_xfer_err = 0;
   logic [NC*DW-1:0] cfg_active;
   logic irq;

   int checks = 0, failures = 0;
   logic [DW-1:0] exp_sh [NC];
   logic [DW-1:0] exp_act [NC];

   always #5 clk = ~clk;

   srr_unit #(.DW(DW), .ADDR_W(AW), .NUM_CFG(NC), .VW(VW)) u_srr_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disp_en(disp_en),
      .vcount(vcount), .vend(vend), .ev_line(ev_line), .ev_underrun(ev_underrun),
      .ev_xfer_err(ev_xfer_err), .cfg_active(cfg_active), .irq(irq));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   function automatic logic [DW-1:0] rd(input int a);
      reg_addr = AW'(a);
      return reg_rdata;
   endfunction

   task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
      reg_addr = AW'(a);
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic chk_active(input string req);
      for (int k = 0; k < NC; k++) check(req, cfg_active[k*DW +: DW], exp_act[k]);
   endtask

   task automatic load_shadow(input logic [DW-1:0] seed);
      for (int k = 0; k < NC; k++) begin
         exp_sh[k] = seed ^ (DW'(k) * 32'h01010101);
         wr(4 + k, exp_sh[k]);
      end
   endtask

   task automatic commit_model();
      for (int k = 0; k < NC; k++) exp_act[k] = exp_sh[k];
   endtask

   task automatic pulse(input logic [2:0] s);
      @(negedge clk);
      ev_line = s[0]; ev_underrun = s[1]; ev_xfer_err = s[2];
      @(negedge clk);
      ev_line = 0; ev_underrun = 0; ev_xfer_err = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int k = 0; k < NC; k++) begin exp_sh[k] = '0; exp_act[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk_active("R1");
      rd_chk("R1", 0, 0); rd_chk("R1", 1, 0); rd_chk("R1", 2, 0);
      for (int k = 0; k < NC; k++) rd_chk("R1", 4 + k, 0);
      check("R1", DW'(irq), 0);

      // R2 shadow write does not touch active
      load_shadow(32'hA5C3_0F11);
      for (int k = 0; k < NC; k++) rd_chk("R2", 4 + k, exp_sh[k]);
      repeat (4) @(negedge clk);
      chk_active("R2");
      rd_chk("R9", 3, 0);

      // R3 immediate commit
      disp_en = 1; vcount = 0;
      wr(0, 1);
      rd_chk("R3", 0, 1);
      chk_active("R3");
      @(negedge clk);
      commit_model();
      chk_active("R3");
      rd_chk("R3", 0, 0);
      rd_chk("R7", 2, 32'h8);
      wr(3, 32'hF);
      rd_chk("R9", 2, 0);

      // R4 vertical blank commit
      load_shadow(32'h1234_5678);
      wr(0, 2);
      repeat (5) @(negedge clk);
      rd_chk("R4", 0, 2);
      chk_active("R4");
      rd_chk("R4", 2, 0);
      vcount = 11'd5;
      @(negedge clk);
      commit_model();
      chk_active("R4");
      rd_chk("R4", 0, 0);
      rd_chk("R7", 2, 32'h8);
      // R4 parked on end line: no new commit
      load_shadow(32'h0BAD_F00D);
      wr(0, 2);
      repeat (4) @(negedge clk);
      rd_chk("R4", 0, 2);
      chk_active("R4");
      vcount = 11'd9;
      @(negedge clk);
      chk_active("R4");
      vcount = 11'd5;
      @(negedge clk);
      commit_model();
      chk_active("R4");
      rd_chk("R4", 0, 0);
      vcount = 0;

      // R5 display off: vertical blank request acts at once
      disp_en = 0;
      load_shadow(32'hFEED_0001);
      wr(0, 2);
      rd_chk("R5", 0, 2);
      @(negedge clk);
      commit_model();
      chk_active("R5");
      rd_chk("R5", 0, 0);

      // R6 both requests, single copy
      disp_en = 1;
      load_shadow(32'h7777_0002);
      wr(3, 32'hF);
      wr(0, 3);
      rd_chk("R6", 0, 3);
      @(negedge clk);
      commit_model();
      chk_active("R6");
      rd_chk("R6", 0, 0);
      rd_chk("R7", 2, 32'h8);
      repeat (3) @(negedge clk);
      chk_active("R6");

      // R8 + R11 sweep of enables against source patterns
      for (int e = 0; e < 16; e++) begin
         for (int s = 0; s < 8; s++) begin
            wr(3, 32'hF);
            wr(1, DW'(e));
            pulse(3'(s));
            rd_chk("R8", 2, DW'(s));
            check("R11", DW'(irq), DW'(|(4'(s) & 4'(e))));
         end
      end
      // R11 commit-done bit drives irq through its enable
      wr(3, 32'hF);
      wr(1, 32'h8);
      check("R11", DW'(irq), 0);
      wr(0, 1);
      @(negedge clk);
      commit_model();
      check("R11", DW'(irq), 1);
      rd_chk("R11", 1, 32'h8);

      // R9 partial clear
      wr(3, 32'hF);
      wr(1, 0);
      pulse(3'b111);
      wr(3, 32'h5);
      rd_chk("R9", 2, 32'h2);
      wr(3, 32'h2);
      rd_chk("R9", 2, 0);

      // R10 clear and event in the same cycle
      pulse(3'b010);
      @(negedge clk);
      reg_wr = 1; reg_addr = AW'(3); reg_wdata = 32'h2; ev_underrun = 1;
      @(negedge clk);
      reg_wr = 0; ev_underrun = 0;
      rd_chk("R10", 2, 32'h2);
      wr(3, 32'h2);
      rd_chk("R10", 2, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule